// File: doc/BRIEF.md
# Flash Block Protection Enforcement Unit

This unit sits between the flash access path and the flash array and decides, for every request, whether the access may proceed. Flash space is split into 2 KB blocks. Each block owns two permission bits: a read permission and a program permission. A request carries an access kind and a byte address. The unit answers one cycle later with exactly one of three outcomes: granted, refused with a bus fault (read-type kinds), or refused as blocked (program-type kinds). A blocked program or erase also raises an access-violation event.

Permission bits live in two copies. A committed copy models the permanent store and returns to open access only on the store reset. A working copy is loaded from the committed copy after every power-on reset. Software may only clear working bits. A keyed commit strobe copies the working bits into the committed copy. A debug-access field follows the same clear-then-commit rules. The debug-port enable it drives is sampled only during the load after power-on.

Two interrupt sources are kept: access violation and program complete. Each has a raw flag, a mask bit, and a masked view. Flags are cleared by writing 1. The interrupt output is the OR of the masked flags.

Top module: `flash_guard`

## Requirements
- R1: After the store reset and a power-on reset, once `ready` is 1: every bit of `rd_perm` and `pg_perm` reads 1, `dbg_field` reads 2'b10, `dbg_port_en` is 1, and `raw_stat`, `masked_stat` and `irq` are 0.
- R2: A read (`req_kind`=0) gets its response on the cycle after the request. It is granted when the addressed block's read permission is 1; otherwise `rsp_fault` is raised.
- R3: An execute (`req_kind`=1) is granted when either permission bit of the block is 1. With both bits 0, it is refused with `rsp_fault`.
- R4: A program (`req_kind`=2) or erase (`req_kind`=3) is granted when the block's program permission is 1. Otherwise it gets `rsp_blocked` and sets the access-violation raw flag (bit 0 of `raw_stat`).
- R5: A permission write gives new = old AND `perm_wr_data`. `perm_wr_sel`=0 selects read permissions and 1 selects program permissions. A 0 bit can never be set back to 1 by a write.
- R6: A power-on reset replaces every working permission bit and the debug field with the committed value. Uncommitted clears are lost; committed clears remain.
- R7: A commit pulse takes effect only when `commit_key` equals the `COMMIT_KEY` parameter. A commit with any other key leaves the committed copy unchanged.
- R8: `raw_stat` shows events whatever the mask. `masked_stat` = `raw_stat` AND `irq_mask`, where `irq_mask` is loaded by `mask_wr`. `irq` is the OR of `masked_stat`.
- R9: Writing 1 to a bit through `clr_wr`/`clr_data` clears that raw flag, which also clears its masked view. Bits written 0 are untouched. An event arriving in the same cycle as its clear leaves the flag set.
- R10: A `prog_done` pulse sets the program-complete raw flag (bit 1 of `raw_stat`).
- R11: The debug field accepts only clears. `dbg_port_en` is 1 only when the field held 2'b10 at the last power-on load. It never changes between power-on resets.
- R12: The block index is `req_addr[11 +: log2(NUM_BLK)]`. The low 11 address bits do not affect the decision.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, asynchronous active low |
| store_rst_n | input | 1 | Permanent-store reset model, asynchronous active low |
| ready | output | 1 | Working copy loaded; requests accepted |
| req_valid | input | 1 | Access request strobe |
| req_kind | input | 2 | 0 read, 1 execute, 2 program, 3 erase |
| req_addr | input | ADDR_W | Byte address of the access |
| rsp_valid | output | 1 | Response valid, one cycle after request |
| rsp_ok | output | 1 | Access granted |
| rsp_fault | output | 1 | Read-type access refused (bus fault) |
| rsp_blocked | output | 1 | Program-type access refused |
| perm_wr | input | 1 | Permission clear write strobe |
| perm_wr_sel | input | 1 | 0 read permissions, 1 program permissions |
| perm_wr_data | input | NUM_BLK | AND mask applied to the selected word |
| dbg_wr | input | 1 | Debug field clear write strobe |
| dbg_wr_data | input | 2 | AND mask applied to the debug field |
| commit_stb | input | 1 | Commit pulse |
| commit_key | input | KEY_W | Key presented with the commit |
| rd_perm | output | NUM_BLK | Working read permissions |
| pg_perm | output | NUM_BLK | Working program permissions |
| dbg_field | output | 2 | Working debug field |
| dbg_port_en | output | 1 | Debug port enable latched at power-on |
| prog_done | input | 1 | Program or erase finished pulse |
| mask_wr | input | 1 | Interrupt mask write strobe |
| mask_data | input | 2 | New mask (bit 0 violation, bit 1 complete) |
| clr_wr | input | 1 | Interrupt clear strobe |
| clr_data | input | 2 | Write-one-to-clear bits |
| raw_stat | output | 2 | Raw flags (bit 0 violation, bit 1 complete) |
| masked_stat | output | 2 | Raw AND mask |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the unit with `NUM_BLK`=4, which gives a 13-bit address. That is small enough to drive every block's permission pair into each of the three restricted combinations. Addresses at both ends of a block show that the index is taken from bits 11 and up. `COMMIT_KEY` is set to a non-default value, so a commit using the default key counts as a wrong key. Power-on resets issued before and after a valid commit show which clears survive. They also show when the debug port enable is allowed to move.

// File: rtl/flash_guard_pkg.sv
package flash_guard_pkg;
  typedef enum logic [1:0] {
    ACC_READ  = 2'd0,
    ACC_EXEC  = 2'd1,
    ACC_PROG  = 2'd2,
    ACC_ERASE = 2'd3
  } acc_kind_e;

  localparam int BLK_SHIFT = 11;
  localparam int IRQ_W     = 2;
  localparam int IRQ_AV    = 0;
  localparam int IRQ_PC    = 1;
  localparam int DBG_W     = 2;
  localparam logic [DBG_W-1:0] DBG_OPEN = 2'b10;
endpackage

// File: rtl/fg_rst_sync.sv
module fg_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= '0;
    else         chain_q <= chain_d;
  end

  assign srst_n = chain_q[STAGES-1];
endmodule

// File: rtl/fg_prot_store.sv
module fg_prot_store
  import flash_guard_pkg::*;
#(
  parameter int NUM_BLK = 8,
  parameter int KEY_W   = 16,
  parameter logic [KEY_W-1:0] COMMIT_KEY = 16'hA5C3
) (
  input  logic               clk,
  input  logic               por_rst_n,
  input  logic               store_rst_n,
  input  logic               perm_wr,
  input  logic               perm_wr_sel,
  input  logic [NUM_BLK-1:0] perm_wr_data,
  input  logic               dbg_wr,
  input  logic [DBG_W-1:0]   dbg_wr_data,
  input  logic               commit_stb,
  input  logic [KEY_W-1:0]   commit_key,
  output logic               ready,
  output logic [NUM_BLK-1:0] rd_perm,
  output logic [NUM_BLK-1:0] pg_perm,
  output logic [DBG_W-1:0]   dbg_field,
  output logic               dbg_port_en
);
  // committed copy (permanent store model)
  logic [NUM_BLK-1:0] cm_rd_q, cm_pg_q;
  logic [DBG_W-1:0]   cm_dbg_q;
  logic               commit_ok;

  // working copy
  logic [NUM_BLK-1:0] wk_rd_q, wk_rd_d, wk_pg_q, wk_pg_d;
  logic [DBG_W-1:0]   wk_dbg_q, wk_dbg_d;
  logic               loaded_q, dport_q, dport_d;
  logic               wk_en;

  assign commit_ok = commit_stb && loaded_q && (commit_key == COMMIT_KEY);

  always_ff @(posedge clk or negedge store_rst_n) begin
    if (!store_rst_n) begin
      cm_rd_q  <= '1;
      cm_pg_q  <= '1;
      cm_dbg_q <= DBG_OPEN;
    end else if (commit_ok) begin
      cm_rd_q  <= wk_rd_q;
      cm_pg_q  <= wk_pg_q;
      cm_dbg_q <= wk_dbg_q;
    end
  end

  always_comb begin
    wk_rd_d  = wk_rd_q;
    wk_pg_d  = wk_pg_q;
    wk_dbg_d = wk_dbg_q;
    dport_d  = dport_q;
    if (!loaded_q) begin
      wk_rd_d  = cm_rd_q;
      wk_pg_d  = cm_pg_q;
      wk_dbg_d = cm_dbg_q;
      dport_d  = (cm_dbg_q == DBG_OPEN);
    end else begin
      if (perm_wr && !perm_wr_sel) wk_rd_d = wk_rd_q & perm_wr_data;
      if (perm_wr &&  perm_wr_sel) wk_pg_d = wk_pg_q & perm_wr_data;
      if (dbg_wr)                  wk_dbg_d = wk_dbg_q & dbg_wr_data;
    end
  end

  assign wk_en = !loaded_q || perm_wr || dbg_wr;

  always_ff @(posedge clk or negedge por_rst_n) begin
    if (!por_rst_n) begin
      loaded_q <= 1'b0;
      wk_rd_q  <= '0;
      wk_pg_q  <= '0;
      wk_dbg_q <= '0;
      dport_q  <= 1'b0;
    end else begin
      loaded_q <= 1'b1;
      if (wk_en) begin
        wk_rd_q  <= wk_rd_d;
        wk_pg_q  <= wk_pg_d;
        wk_dbg_q <= wk_dbg_d;
      end
      if (!loaded_q) dport_q <= dport_d;
    end
  end

  assign ready       = loaded_q;
  assign rd_perm     = wk_rd_q;
  assign pg_perm     = wk_pg_q;
  assign dbg_field   = wk_dbg_q;
  assign dbg_port_en = dport_q;

  // R5
  rd_never_sets_chk: assert property (@(posedge clk) disable iff (!por_rst_n)
    (loaded_q && $past(loaded_q)) |-> ((wk_rd_q & ~$past(wk_rd_q)) == '0));
  // R5
  pg_never_sets_chk: assert property (@(posedge clk) disable iff (!por_rst_n)
    (loaded_q && $past(loaded_q)) |-> ((wk_pg_q & ~$past(wk_pg_q)) == '0));
  // R7
  commit_keyed_chk: assert property (@(posedge clk) disable iff (!store_rst_n || !por_rst_n)
    (cm_rd_q != $past(cm_rd_q) || cm_pg_q != $past(cm_pg_q)) |->
      ($past(commit_stb) && $past(commit_key) == COMMIT_KEY));
  // R11
  dport_hold_chk: assert property (@(posedge clk) disable iff (!por_rst_n)
    (loaded_q && $past(loaded_q)) |-> $stable(dport_q));
endmodule

// File: rtl/fg_access_check.sv
module fg_access_check
  import flash_guard_pkg::*;
#(
  parameter int NUM_BLK = 8,
  parameter int ADDR_W  = 14
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ready,
  input  logic               req_valid,
  input  logic [1:0]         req_kind,
  input  logic [ADDR_W-1:0]  req_addr,
  input  logic [NUM_BLK-1:0] rd_perm,
  input  logic [NUM_BLK-1:0] pg_perm,
  output logic               rsp_valid,
  output logic               rsp_ok,
  output logic               rsp_fault,
  output logic               rsp_blocked,
  output logic               av_evt
);
  localparam int IDX_W = (NUM_BLK > 1) ? $clog2(NUM_BLK) : 1;

  acc_kind_e          kind;
  logic [IDX_W-1:0]   blk;
  logic               r_ok, p_ok, accept, grant, is_prog;
  logic               v_d, ok_d, flt_d, blk_d;
  logic               unused_addr_lo;

  assign kind           = acc_kind_e'(req_kind);
  assign blk            = req_addr[BLK_SHIFT +: IDX_W];
  assign unused_addr_lo = ^req_addr[BLK_SHIFT-1:0];
  assign r_ok           = rd_perm[blk];
  assign p_ok           = pg_perm[blk];
  assign accept         = req_valid && ready;
  assign is_prog        = (kind == ACC_PROG) || (kind == ACC_ERASE);

  always_comb begin
    unique case (kind)
      ACC_READ:  grant = r_ok;
      ACC_EXEC:  grant = r_ok || p_ok;
      default:   grant = p_ok;
    endcase
    v_d   = accept;
    ok_d  = accept && grant;
    flt_d = accept && !grant && !is_prog;
    blk_d = accept && !grant &&  is_prog;
  end

  assign av_evt = blk_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid   <= 1'b0;
      rsp_ok      <= 1'b0;
      rsp_fault   <= 1'b0;
      rsp_blocked <= 1'b0;
    end else begin
      rsp_valid   <= v_d;
      rsp_ok      <= ok_d;
      rsp_fault   <= flt_d;
      rsp_blocked <= blk_d;
    end
  end

  // R2
  fault_read_type_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_fault |-> ($past(req_kind) == 2'd0 || $past(req_kind) == 2'd1));
  // R4
  blocked_prog_type_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_blocked |-> ($past(req_kind) == 2'd2 || $past(req_kind) == 2'd3));
  // R2
  one_outcome_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $countones({rsp_ok, rsp_fault, rsp_blocked}) == 1);
endmodule

// File: rtl/fg_irq_ctrl.sv
module fg_irq_ctrl
  import flash_guard_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             av_evt,
  input  logic             pc_evt,
  input  logic             mask_wr,
  input  logic [IRQ_W-1:0] mask_data,
  input  logic             clr_wr,
  input  logic [IRQ_W-1:0] clr_data,
  output logic [IRQ_W-1:0] raw_stat,
  output logic [IRQ_W-1:0] masked_stat,
  output logic             irq
);
  logic [IRQ_W-1:0] raw_q, raw_d, mask_q, set_v, clr_v;

  always_comb begin
    set_v          = '0;
    set_v[IRQ_AV]  = av_evt;
    set_v[IRQ_PC]  = pc_evt;
    clr_v          = clr_wr ? clr_data : '0;
    raw_d          = (raw_q & ~clr_v) | set_v;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      raw_q  <= '0;
      mask_q <= '0;
    end else begin
      raw_q <= raw_d;
      if (mask_wr) mask_q <= mask_data;
    end
  end

  assign raw_stat    = raw_q;
  assign masked_stat = raw_q & mask_q;
  assign irq         = |masked_stat;

  // R4
  av_rise_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(raw_q[IRQ_AV]) |-> $past(av_evt));
  // R10
  pc_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(pc_evt) |-> raw_q[IRQ_PC]);
  // R9
  clear_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(clr_wr) && $past(clr_data[IRQ_AV]) && !$past(av_evt)) |-> !raw_q[IRQ_AV]);
endmodule

// File: rtl/flash_guard.sv
module flash_guard
  import flash_guard_pkg::*;
#(
  parameter int NUM_BLK = 8,
  parameter int ADDR_W  = BLK_SHIFT + ((NUM_BLK > 1) ? $clog2(NUM_BLK) : 1),
  parameter int KEY_W   = 16,
  parameter logic [KEY_W-1:0] COMMIT_KEY = 16'hA5C3
) (
  input  logic               clk,
  input  logic               por_n,
  input  logic               store_rst_n,
  output logic               ready,
  input  logic               req_valid,
  input  logic [1:0]         req_kind,
  input  logic [ADDR_W-1:0]  req_addr,
  output logic               rsp_valid,
  output logic               rsp_ok,
  output logic               rsp_fault,
  output logic               rsp_blocked,
  input  logic               perm_wr,
  input  logic               perm_wr_sel,
  input  logic [NUM_BLK-1:0] perm_wr_data,
  input  logic               dbg_wr,
  input  logic [1:0]         dbg_wr_data,
  input  logic               commit_stb,
  input  logic [KEY_W-1:0]   commit_key,
  output logic [NUM_BLK-1:0] rd_perm,
  output logic [NUM_BLK-1:0] pg_perm,
  output logic [1:0]         dbg_field,
  output logic               dbg_port_en,
  input  logic               prog_done,
  input  logic               mask_wr,
  input  logic [1:0]         mask_data,
  input  logic               clr_wr,
  input  logic [1:0]         clr_data,
  output logic [1:0]         raw_stat,
  output logic [1:0]         masked_stat,
  output logic               irq
);
  logic por_rst_n, st_rst_n, av_evt;

  fg_rst_sync u_por_sync (.clk(clk), .arst_n(por_n),       .srst_n(por_rst_n));
  fg_rst_sync u_st_sync  (.clk(clk), .arst_n(store_rst_n), .srst_n(st_rst_n));

  fg_prot_store #(
    .NUM_BLK(NUM_BLK), .KEY_W(KEY_W), .COMMIT_KEY(COMMIT_KEY)
  ) u_store (
    .clk(clk), .por_rst_n(por_rst_n), .store_rst_n(st_rst_n),
    .perm_wr(perm_wr), .perm_wr_sel(perm_wr_sel), .perm_wr_data(perm_wr_data),
    .dbg_wr(dbg_wr), .dbg_wr_data(dbg_wr_data),
    .commit_stb(commit_stb), .commit_key(commit_key),
    .ready(ready), .rd_perm(rd_perm), .pg_perm(pg_perm),
    .dbg_field(dbg_field), .dbg_port_en(dbg_port_en)
  );

  fg_access_check #(.NUM_BLK(NUM_BLK), .ADDR_W(ADDR_W)) u_check (
    .clk(clk), .rst_n(por_rst_n), .ready(ready),
    .req_valid(req_valid), .req_kind(req_kind), .req_addr(req_addr),
    .rd_perm(rd_perm), .pg_perm(pg_perm),
    .rsp_valid(rsp_valid), .rsp_ok(rsp_ok), .rsp_fault(rsp_fault),
    .rsp_blocked(rsp_blocked), .av_evt(av_evt)
  );

  fg_irq_ctrl u_irq (
    .clk(clk), .rst_n(por_rst_n), .av_evt(av_evt), .pc_evt(prog_done),
    .mask_wr(mask_wr), .mask_data(mask_data),
    .clr_wr(clr_wr), .clr_data(clr_data),
    .raw_stat(raw_stat), .masked_stat(masked_stat), .irq(irq)
  );
endmodule

// File: tb/flash_guard_test.sv
module flash_guard_test;
  localparam int NB = 4;
  localparam int AW = 13;
  localparam int KW = 16;
  localparam logic [KW-1:0] KEY = 16'h3C5A;

  logic clk = 1'b0;
  logic por_n, store_rst_n, ready;
  logic req_valid; logic [1:0] req_kind; logic [AW-1:0] req_addr;
  logic rsp_valid, rsp_ok, rsp_fault, rsp_blocked;
  logic perm_wr, perm_wr_sel; logic [NB-1:0] perm_wr_data;
  logic dbg_wr; logic [1:0] dbg_wr_data;
  logic commit_stb; logic [KW-1:0] commit_key;
  logic [NB-1:0] rd_perm, pg_perm; logic [1:0] dbg_field; logic dbg_port_en;
  logic prog_done, mask_wr, clr_wr; logic [1:0] mask_data, clr_data;
  logic [1:0] raw_stat, masked_stat; logic irq;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  flash_guard #(.NUM_BLK(NB), .ADDR_W(AW), .KEY_W(KW), .COMMIT_KEY(KEY)) uut (
    .clk(clk), .por_n(por_n), .store_rst_n(store_rst_n), .ready(ready),
    .req_valid(req_valid), .req_kind(req_kind), .req_addr(req_addr),
    .rsp_valid(rsp_valid), .rsp_ok(rsp_ok), .rsp_fault(rsp_fault), .rsp_blocked(rsp_blocked),
    .perm_wr(perm_wr), .perm_wr_sel(perm_wr_sel), .perm_wr_data(perm_wr_data),
    .dbg_wr(dbg_wr), .dbg_wr_data(dbg_wr_data),
    .commit_stb(commit_stb), .commit_key(commit_key),
    .rd_perm(rd_perm), .pg_perm(pg_perm), .dbg_field(dbg_field), .dbg_port_en(dbg_port_en),
    .prog_done(prog_done), .mask_wr(mask_wr), .mask_data(mask_data),
    .clr_wr(clr_wr), .clr_data(clr_data),
    .raw_stat(raw_stat), .masked_stat(masked_stat), .irq(irq)
  );

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic idle_inputs();
    req_valid = 0; req_kind = 0; req_addr = '0;
    perm_wr = 0; perm_wr_sel = 0; perm_wr_data = '1;
    dbg_wr = 0; dbg_wr_data = 2'b11; commit_stb = 0; commit_key = '0;
    prog_done = 0; mask_wr = 0; mask_data = 0; clr_wr = 0; clr_data = 0;
  endtask

  task automatic power_on();
    @(negedge clk); por_n = 0;
    repeat (3) @(negedge clk);
    por_n = 1;
    for (int i = 0; i < 20 && !ready; i++) @(negedge clk);
  endtask

  // response word {ok, fault, blocked}
  task automatic access(string req, logic [1:0] kind, logic [AW-1:0] a, logic [2:0] exp);
    @(negedge clk);
    req_valid = 1; req_kind = kind; req_addr = a;
    @(negedge clk);
    req_valid = 0;
    chk(req, "rsp_valid", rsp_valid, 1);
    chk(req, "response", {rsp_ok, rsp_fault, rsp_blocked}, exp);
  endtask

  task automatic wr_perm(logic sel, logic [NB-1:0] d);
    @(negedge clk); perm_wr = 1; perm_wr_sel = sel; perm_wr_data = d;
    @(negedge clk); perm_wr = 0; perm_wr_data = '1;
  endtask

  task automatic wr_dbg(logic [1:0] d);
    @(negedge clk); dbg_wr = 1; dbg_wr_data = d;
    @(negedge clk); dbg_wr = 0; dbg_wr_data = 2'b11;
  endtask

  task automatic commit(logic [KW-1:0] k);
    @(negedge clk); commit_stb = 1; commit_key = k;
    @(negedge clk); commit_stb = 0; commit_key = '0;
  endtask

  task automatic t_reset();
    chk("R1", "ready", ready, 1);
    chk("R1", "rd_perm", rd_perm, 4'hF);
    chk("R1", "pg_perm", pg_perm, 4'hF);
    chk("R1", "dbg_field", dbg_field, 2'b10);
    chk("R1", "dbg_port_en", dbg_port_en, 1);
    chk("R1", "raw_stat", raw_stat, 0);
    chk("R1", "masked/irq", {masked_stat, irq}, 0);
  endtask

  task automatic t_open();
    access("R2", 2'd0, 13'h0000, 3'b100);
    access("R3", 2'd1, 13'h1FFF, 3'b100);
    access("R4", 2'd2, 13'h0800, 3'b100);
    access("R4", 2'd3, 13'h1800, 3'b100);
    chk("R4", "no violation when open", raw_stat[0], 0);
  endtask

  task automatic t_clear_only();
    wr_perm(1'b0, 4'b1101);
    chk("R5", "rd cleared", rd_perm, 4'b1101);
    chk("R5", "pg untouched", pg_perm, 4'hF);
    wr_perm(1'b0, 4'b1111);
    chk("R5", "rd not set again", rd_perm, 4'b1101);
  endtask

  task automatic t_read_protect();
    access("R2", 2'd0, 13'h0800, 3'b010);
    access("R12", 2'd0, 13'h0FFF, 3'b010);
    access("R12", 2'd0, 13'h07FF, 3'b100);
    access("R12", 2'd0, 13'h1000, 3'b100);
    access("R3", 2'd1, 13'h0A00, 3'b100);
    access("R4", 2'd2, 13'h0A00, 3'b100);
  endtask

  task automatic t_prog_protect();
    wr_perm(1'b1, 4'b1011);
    chk("R5", "pg cleared", pg_perm, 4'b1011);
    access("R4", 2'd2, 13'h1004, 3'b001);
    chk("R4", "violation flag", raw_stat[0], 1);
    chk("R8", "masked off irq", {masked_stat, irq}, 0);
    access("R4", 2'd3, 13'h17FC, 3'b001);
    access("R2", 2'd0, 13'h1004, 3'b100);
    access("R3", 2'd1, 13'h1004, 3'b100);
  endtask

  task automatic t_both_clear();
    wr_perm(1'b0, 4'b0111);
    wr_perm(1'b1, 4'b0111);
    access("R3", 2'd1, 13'h1800, 3'b010);
    access("R2", 2'd0, 13'h1800, 3'b010);
    access("R4", 2'd2, 13'h1800, 3'b001);
  endtask

  task automatic t_irq();
    @(negedge clk); clr_wr = 1; clr_data = 2'b11;
    @(negedge clk); clr_wr = 0;
    chk("R9", "raw cleared", raw_stat, 0);
    access("R4", 2'd2, 13'h1000, 3'b001);
    @(negedge clk); mask_wr = 1; mask_data = 2'b01;
    @(negedge clk); mask_wr = 0;
    chk("R8", "masked violation", masked_stat, 2'b01);
    chk("R8", "irq on", irq, 1);
    @(negedge clk); prog_done = 1;
    @(negedge clk); prog_done = 0;
    chk("R10", "complete flag", raw_stat, 2'b11);
    chk("R8", "mask hides complete", masked_stat, 2'b01);
    @(negedge clk); mask_wr = 1; mask_data = 2'b10;
    @(negedge clk); mask_wr = 0;
    chk("R8", "masked complete", masked_stat, 2'b10);
    @(negedge clk); clr_wr = 1; clr_data = 2'b10; prog_done = 1;
    @(negedge clk); clr_wr = 0; prog_done = 0;
    chk("R9", "set beats clear", raw_stat, 2'b11);
    @(negedge clk); clr_wr = 1; clr_data = 2'b10;
    @(negedge clk); clr_wr = 0;
    chk("R9", "only bit1 cleared", raw_stat, 2'b01);
    chk("R9", "irq off", {masked_stat, irq}, 0);
  endtask

  task automatic t_bad_commit();
    wr_dbg(2'b01);
    chk("R11", "dbg cleared", dbg_field, 2'b00);
    chk("R11", "port held", dbg_port_en, 1);
    commit(16'hA5C3);
    power_on();
    chk("R7", "rd restored", rd_perm, 4'hF);
    chk("R6", "pg restored", pg_perm, 4'hF);
    chk("R6", "dbg restored", dbg_field, 2'b10);
    chk("R11", "port still on", dbg_port_en, 1);
    chk("R6", "raw reset", raw_stat, 0);
  endtask

  task automatic t_commit();
    wr_perm(1'b0, 4'b1101);
    wr_perm(1'b1, 4'b1011);
    wr_dbg(2'b01);
    commit(KEY);
    chk("R11", "port until power-up", dbg_port_en, 1);
    wr_perm(1'b0, 4'b1110);
    chk("R5", "later clear", rd_perm, 4'b1100);
    power_on();
    chk("R6", "rd committed", rd_perm, 4'b1101);
    chk("R6", "pg committed", pg_perm, 4'b1011);
    chk("R11", "dbg committed", dbg_field, 2'b00);
    chk("R11", "port off", dbg_port_en, 0);
    access("R6", 2'd0, 13'h0800, 3'b010);
    access("R6", 2'd0, 13'h0000, 3'b100);
  endtask

  initial begin
    idle_inputs();
    por_n = 0; store_rst_n = 0;
    repeat (3) @(negedge clk);
    store_rst_n = 1;
    power_on();
    t_reset();
    t_open();
    t_clear_only();
    t_read_protect();
    t_prog_protect();
    t_both_clear();
    t_irq();
    t_bad_commit();
    t_commit();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule